// File: doc/BRIEF.md
# Dual-View Frame Buffer CPU Port

This block gives a processor a 16-bit window onto a frame buffer of 16-bit pixels. Each pixel has two halves: a data byte in its low half and a colour (palette) byte in its high half. One processor word covers two neighbouring pixels. The low byte lane of the word reaches the even pixel and the high byte lane reaches the odd pixel. The frame buffer is held inside the block as plain RAM.

Each access picks one of three apertures. The banked aperture follows a view bit in a control word. The two fixed apertures always show the data halves or always show the colour halves, whatever the control word says. A write in data view stores the byte in the pixel's low half and fills the high half from a palette register. A write in colour view replaces only the high half and leaves the data byte as it was. Reads return the matching halves of both pixels one cycle after the request.

Top module: `vram_port`

## Requirements
- R1: After reset, rd_valid and rd_data are 0, the palette register is 0, and the banked aperture is in colour view (view bit 0).
- R2: Word address N reaches pixel 2N through byte lane 0 (bits 7:0) and pixel 2N+1 through byte lane 1 (bits 15:8). Different word addresses never alias.
- R3: A data-view write with acc_be[0]=1 sets pixel 2N to {palette[7:0], acc_wdata[7:0]}.
- R4: A data-view write with acc_be[1]=1 sets pixel 2N+1 to {palette[15:8], acc_wdata[15:8]}.
- R5: A colour-view write puts acc_wdata[7:0] into the high half of pixel 2N (lane 0) and acc_wdata[15:8] into the high half of pixel 2N+1 (lane 1). The low halves of both pixels are kept.
- R6: A data-view read returns {low half of pixel 2N+1, low half of pixel 2N}. A colour-view read returns {high half of pixel 2N+1, high half of pixel 2N}.
- R7: A control write loads the view bit from ctrl_wdata[5]: 1 selects data view and 0 selects colour view. The other control bits have no effect. The new view applies from the next access.
- R8: With acc_fixed=1, acc_color chooses the view (0 data, 1 colour) and the view bit is ignored. With acc_fixed=0, the view bit decides.
- R9: A read (acc_en=1, acc_we=0) raises rd_valid for exactly one cycle, on the cycle after the request, with the read word on rd_data. rd_data holds its value until the next read. Writes never raise rd_valid.
- R10: The two byte lanes act independently. A lane whose enable is 0 leaves its pixel untouched, and a write with both enables 0 changes nothing.
- R11: The palette bytes are taken at the time of the write. A later palette change does not alter pixels already written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Load the control word |
| ctrl_wdata | input | 16 | Control word; bit 5 is the view bit |
| pal_we | input | 1 | Load the palette register |
| pal_wdata | input | 16 | Palette value; one byte per lane |
| acc_en | input | 1 | Access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_fixed | input | 1 | Use a fixed aperture instead of the banked one |
| acc_color | input | 1 | Fixed aperture choice: 0 data, 1 colour |
| acc_addr | input | ADDR_W | Word address |
| acc_be | input | 2 | Byte-lane enables |
| acc_wdata | input | 16 | Write word |
| rd_data | output | 16 | Read word |
| rd_valid | output | 1 | rd_data was updated by a read this cycle |

## Verification
A wrong view bit shows up on the very next banked read: the word comes back from the wrong half of the pixels. A write that goes to the wrong half, or that takes the wrong palette byte, stays hidden until that word is read through the fixed aperture of the other half. For this reason every write scenario reads the word back through both fixed apertures. A lane that writes when its enable is off corrupts the other pixel of the word. This is caught by checking, after each partial write, the pixel whose lane was off.

// File: rtl/vram_port.sv
module vram_port #(
  parameter int ADDR_W   = 8,
  parameter int VIEW_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [15:0]       ctrl_wdata,
  input  logic              pal_we,
  input  logic [15:0]       pal_wdata,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic              acc_fixed,
  input  logic              acc_color,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_be,
  input  logic [15:0]       acc_wdata,
  output logic [15:0]       rd_data,
  output logic              rd_valid
);
  localparam int WORDS = 2 ** ADDR_W;

  logic        view_data_q;
  logic [15:0] pal_q;
  logic [15:0] rd_mux;

  wire use_color = acc_fixed ? acc_color : ~view_data_q;
  wire do_wr     = acc_en & acc_we;
  wire do_rd     = acc_en & ~acc_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      view_data_q <= 1'b0;
      pal_q       <= '0;
    end else begin
      if (ctrl_we) view_data_q <= ctrl_wdata[VIEW_BIT];
      if (pal_we)  pal_q       <= pal_wdata;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [7:0] lo_mem [WORDS];
    logic [7:0] hi_mem [WORDS];
    wire  [7:0] wbyte = acc_wdata[8*g +: 8];

    always_ff @(posedge clk) begin
      if (do_wr && acc_be[g]) begin
        hi_mem[acc_addr] <= use_color ? wbyte : pal_q[8*g +: 8];
        if (!use_color) lo_mem[acc_addr] <= wbyte;
      end
    end

    assign rd_mux[8*g +: 8] = use_color ? hi_mem[acc_addr] : lo_mem[acc_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) rd_data <= rd_mux;
    end
  end
endmodule

module vram_port_chk #(
  parameter int VIEW_BIT = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_en,
  input logic        acc_we,
  input logic        ctrl_we,
  input logic [15:0] ctrl_wdata,
  input logic [15:0] rd_data,
  input logic        rd_valid,
  input logic        view
);
  a_r9_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we) |=> rd_valid);

  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_we) |=> !rd_valid);

  a_r9_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_we) |=> $stable(rd_data));

  a_r7_view_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (view == $past(ctrl_wdata[VIEW_BIT])));

  a_r7_view_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(view));
endmodule

bind vram_port vram_port_chk #(.VIEW_BIT(VIEW_BIT)) chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
  .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .rd_data(rd_data),
  .rd_valid(rd_valid), .view(view_data_q)
);

// File: tb/vram_port_test.sv
module vram_port_test;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 1'b0, pal_we = 1'b0;
  logic [15:0] ctrl_wdata = '0, pal_wdata = '0;
  logic acc_en = 1'b0, acc_we = 1'b0, acc_fixed = 1'b0, acc_color = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0] acc_be = '0;
  logic [15:0] acc_wdata = '0;
  logic [15:0] rd_data;
  logic rd_valid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vram_port #(.ADDR_W(AW)) uut (
    .clk, .rst_n, .ctrl_we, .ctrl_wdata, .pal_we, .pal_wdata,
    .acc_en, .acc_we, .acc_fixed, .acc_color, .acc_addr, .acc_be,
    .acc_wdata, .rd_data, .rd_valid
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_view(input logic [15:0] w);
    ctrl_we = 1'b1; ctrl_wdata = w;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic set_pal(input logic [15:0] p);
    pal_we = 1'b1; pal_wdata = p;
    @(negedge clk); pal_we = 1'b0;
  endtask

  task automatic wr(input logic fx, input logic col, input logic [AW-1:0] a,
                    input logic [1:0] be, input logic [15:0] d);
    acc_en = 1'b1; acc_we = 1'b1; acc_fixed = fx; acc_color = col;
    acc_addr = a; acc_be = be; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic rd(input logic fx, input logic col, input logic [AW-1:0] a,
                    output logic [15:0] d);
    acc_en = 1'b1; acc_we = 1'b0; acc_fixed = fx; acc_color = col; acc_addr = a;
    @(negedge clk);
    acc_en = 1'b0;
    d = rd_data;
  endtask

  task automatic both(input string req, input logic [AW-1:0] a,
                      input logic [15:0] exp_d, input logic [15:0] exp_c);
    logic [15:0] v;
    rd(1'b1, 1'b0, a, v); chk({req, " data halves"}, v, exp_d);
    rd(1'b1, 1'b1, a, v); chk({req, " colour halves"}, v, exp_c);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1 rd_valid", {15'd0, rd_valid}, 16'd0);
    chk("R1 rd_data", rd_data, 16'd0);
    wr(1'b1, 1'b0, 8'd3, 2'b11, 16'h1234);
    both("R1 palette zero", 8'd3, 16'h1234, 16'h0000);
    wr(1'b1, 1'b1, 8'd3, 2'b11, 16'h5566);
    rd(1'b0, 1'b0, 8'd3, v);
    chk("R1 banked view is colour", v, 16'h5566);
  endtask

  task automatic t_data_write;
    set_pal(16'hA5C3);
    set_view(16'h0020);
    wr(1'b0, 1'b0, 8'd5, 2'b11, 16'h7E81);
    both("R3 R4 full data write", 8'd5, 16'h7E81, 16'hA5C3);
  endtask

  task automatic t_lanes;
    set_pal(16'h0102);
    wr(1'b0, 1'b0, 8'd5, 2'b01, 16'hFF11);
    both("R3 R10 low lane only", 8'd5, 16'h7E11, 16'hA502);
    wr(1'b0, 1'b0, 8'd5, 2'b00, 16'hFFFF);
    both("R10 no lanes", 8'd5, 16'h7E11, 16'hA502);
    wr(1'b0, 1'b0, 8'd5, 2'b10, 16'h3355);
    both("R4 R10 high lane only", 8'd5, 16'h3311, 16'h0102);
  endtask

  task automatic t_colour_write;
    set_view(16'hFFDF);
    wr(1'b0, 1'b0, 8'd5, 2'b11, 16'hBEEF);
    both("R5 R7 banked colour write", 8'd5, 16'h3311, 16'hBEEF);
    set_view(16'h0020);
    wr(1'b1, 1'b1, 8'd5, 2'b01, 16'h0044);
    both("R5 R8 fixed colour low lane", 8'd5, 16'h3311, 16'hBE44);
  endtask

  task automatic t_bank_read;
    logic [15:0] v;
    set_view(16'h0020);
    rd(1'b0, 1'b0, 8'd5, v); chk("R6 R7 banked data read", v, 16'h3311);
    set_view(16'hFFDF);
    rd(1'b0, 1'b0, 8'd5, v); chk("R6 R7 banked colour read", v, 16'hBE44);
  endtask

  task automatic t_fixed;
    logic [15:0] v;
    set_view(16'h0000);
    rd(1'b1, 1'b0, 8'd5, v); chk("R8 data aperture in colour view", v, 16'h3311);
    set_pal(16'h0E0F);
    wr(1'b1, 1'b0, 8'd9, 2'b11, 16'h2468);
    both("R8 data aperture write in colour view", 8'd9, 16'h2468, 16'h0E0F);
    set_view(16'h0020);
    rd(1'b1, 1'b1, 8'd5, v); chk("R8 colour aperture in data view", v, 16'hBE44);
  endtask

  task automatic t_mapping;
    set_pal(16'h0000);
    wr(1'b1, 1'b0, 8'd0, 2'b11, 16'hA1B2);
    wr(1'b1, 1'b0, 8'd255, 2'b11, 16'hC3D4);
    wr(1'b1, 1'b0, 8'd128, 2'b11, 16'hE5F6);
    both("R2 word 0", 8'd0, 16'hA1B2, 16'h0000);
    both("R2 last word", 8'd255, 16'hC3D4, 16'h0000);
    both("R2 middle word", 8'd128, 16'hE5F6, 16'h0000);
  endtask

  task automatic t_palette;
    set_pal(16'h1111);
    wr(1'b1, 1'b0, 8'd7, 2'b11, 16'hABCD);
    set_pal(16'h2222);
    both("R11 palette taken at write", 8'd7, 16'hABCD, 16'h1111);
  endtask

  task automatic t_latency;
    logic [15:0] v;
    acc_en = 1'b1; acc_we = 1'b0; acc_fixed = 1'b1; acc_color = 1'b0; acc_addr = 8'd7;
    @(negedge clk);
    acc_en = 1'b0;
    chk("R9 valid one cycle after read", {15'd0, rd_valid}, 16'd1);
    chk("R9 read word", rd_data, 16'hABCD);
    @(negedge clk);
    chk("R9 valid drops", {15'd0, rd_valid}, 16'd0);
    chk("R9 data held", rd_data, 16'hABCD);
    wr(1'b1, 1'b0, 8'd7, 2'b11, 16'h0001);
    chk("R9 write gives no valid", {15'd0, rd_valid}, 16'd0);
    chk("R9 data held over write", rd_data, 16'hABCD);
    rd(1'b1, 1'b0, 8'd7, v);
    chk("R9 back-to-back read", v, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_data_write;
    t_lanes;
    t_colour_write;
    t_bank_read;
    t_fixed;
    t_mapping;
    t_palette;
    t_latency;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule